// File: doc/BRIEF.md
# Byte-Lane Rotating Data Memory

This block is a 32-bit data memory that can load or store one, two or four bytes at any byte address in one clock cycle. An access may straddle a word boundary. The storage is split into four byte-wide banks. Each bank computes its own row index, so the bytes of an access that runs into the next word come from the next row in the banks below the starting lane. Write data is steered onto the banks by rotating it. Read bytes are gathered back, rotated so that the lowest-addressed byte sits in bits 7:0, and then extended to 32 bits.

The memory answers only inside a window of `DEPTH_WORDS*4` bytes that starts at `BASE_ADDR`. Outside that window a store changes nothing and a load returns zero. Reads are combinational from the banks. Stores take effect at the rising clock edge.

Top module: `lanemem_top`

## Requirements
- R1: An active-low asynchronous reset clears every stored byte, so every load in the window returns zero after reset.
- R2: An access hits only when offset = addr - BASE_ADDR (modulo 2^32) satisfies offset + nbytes <= DEPTH_WORDS*4. The default base is 0xC0000000. An access that would run past the last byte misses as a whole.
- R3: The size code is 2'b00 for one byte, 2'b01 for two bytes and 2'b10 for four bytes. The code 2'b11 is reserved: it always misses, so it writes nothing and reads zero.
- R4: A hitting store with `we`=1 writes wdata byte i (bits 8i+7:8i) to address addr+i for every i below nbytes at the rising edge. All other bytes keep their values.
- R5: A hitting load drives rdata bits 8i+7:8i with the byte at address addr+i, for i below nbytes, in the same cycle as the address is presented.
- R6: Loads and stores that cross a word boundary, at any byte alignment, complete in one cycle with the same byte order as aligned accesses.
- R7: With `sext`=1, the bits above the access are copies of bit 7 of the highest-addressed byte. With `sext`=0 they are zero. A four-byte access is not extended.
- R8: A miss leaves the whole memory unchanged and drives rdata to zero.
- R9: During a cycle that stores, rdata shows the contents from before that store. The new contents appear after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the storage |
| addr | input | ADDR_W | Byte address of the lowest byte of the access |
| size | input | 2 | Access size code (00 byte, 01 halfword, 10 word, 11 reserved) |
| we | input | 1 | Store enable |
| wdata | input | 32 | Store data, lowest-addressed byte in bits 7:0 |
| sext | input | 1 | 1 sign-extends a load, 0 zero-extends it |
| rdata | output | 32 | Load data, aligned to bit 0 and extended |

## Verification
The bench builds the memory with `DEPTH_WORDS`=16 at the default base 0xC0000000, which gives a 64-byte window. With so small a window, random addresses land on the last bytes of the window, cross the upper edge of the window and fall just below the base very often. The row wrap of the bank index therefore meets the window check on almost every run. Directed stores next to the window edge test that the wrapped rows stay untouched.

// File: rtl/lanemem_pkg.sv
package lanemem_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  // Number of bytes moved by a size code; zero marks the reserved code.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Position of bank `bank` inside an access starting at lane `low`.
  function automatic logic [1:0] lane_pos(input logic [1:0] bank, input logic [1:0] low);
    return bank - low;
  endfunction

  // Keep the low nb bytes and fill the rest with zero or the top data bit.
  function automatic logic [DATA_W-1:0] extend_bytes(input logic [DATA_W-1:0] raw,
                                                     input logic [2:0] nb,
                                                     input logic sgn);
    logic fill;
    case (nb)
      3'd1: begin
        fill = sgn & raw[7];
        return {{24{fill}}, raw[7:0]};
      end
      3'd2: begin
        fill = sgn & raw[15];
        return {{16{fill}}, raw[15:0]};
      end
      3'd4:    return raw;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/lanemem_decode.sv
module lanemem_decode
  import lanemem_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned DEPTH_WORDS = 64,
  parameter int unsigned ROW_W       = 6
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [1:0]                    size,
  input  logic                          we,
  input  logic [DATA_W-1:0]             wdata,
  output logic                          hit,
  output logic [2:0]                    nbytes,
  output logic [1:0]                    low,
  output logic [LANES-1:0]              lane_we,
  output logic [LANES-1:0][ROW_W-1:0]   lane_row,
  output logic [LANES-1:0][7:0]         lane_wbyte
);

  localparam logic [ADDR_W:0] WIN_BYTES = (ADDR_W+1)'(DEPTH_WORDS) << 2;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W:0]   span_end;
  logic [ROW_W-1:0]  base_row;

  always_comb begin
    offset   = addr - BASE_ADDR;
    nbytes   = size_bytes(size);
    span_end = {1'b0, offset} + (ADDR_W+1)'(nbytes);
    hit      = (nbytes != 3'd0) && (span_end <= WIN_BYTES);
    low      = offset[1:0];
    base_row = offset[ROW_W+1:2];
  end

  // Each bank finds its byte position in the access and its own row.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] pos;
    assign pos           = lane_pos(2'(k), low);
    assign lane_we[k]    = we && hit && ({1'b0, pos} < nbytes);
    assign lane_row[k]   = base_row + ROW_W'(2'(k) < low);
    assign lane_wbyte[k] = wdata[{pos, 3'b000} +: 8];
  end

endmodule

// File: rtl/lanemem_bank.sv
module lanemem_bank #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);

  logic [7:0] cells [ROWS];
  logic       row_ok;

  assign row_ok = (32'(row) < ROWS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else if (we && row_ok) begin
      cells[row] <= wbyte;
    end
  end

  assign rbyte = row_ok ? cells[row] : 8'h00;

endmodule

// File: rtl/lanemem_align.sv
module lanemem_align
  import lanemem_pkg::*;
(
  input  logic                  hit,
  input  logic [2:0]            nbytes,
  input  logic [1:0]            low,
  input  logic                  sext,
  input  logic [LANES-1:0][7:0] lane_rbyte,
  output logic [DATA_W-1:0]     rdata
);

  logic [DATA_W-1:0] gathered;

  // Byte i of the result comes from bank (low + i) mod 4.
  for (genvar i = 0; i < LANES; i++) begin : g_gather
    assign gathered[8*i +: 8] = lane_rbyte[2'(i) + low];
  end

  assign rdata = hit ? extend_bytes(gathered, nbytes, sext) : '0;

endmodule

// File: rtl/lanemem_top.sv
module lanemem_top
  import lanemem_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hC000_0000,
  parameter int unsigned DEPTH_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              sext,
  output logic [31:0]       rdata
);

  localparam int unsigned ROW_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;

  logic                        acc_hit;
  logic [2:0]                  acc_nbytes;
  logic [1:0]                  acc_low;
  logic [LANES-1:0]            lane_we;
  logic [LANES-1:0][ROW_W-1:0] lane_row;
  logic [LANES-1:0][7:0]       lane_wbyte;
  logic [LANES-1:0][7:0]       lane_rbyte;

  lanemem_decode #(
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR),
    .DEPTH_WORDS (DEPTH_WORDS),
    .ROW_W       (ROW_W)
  ) i_decode (
    .addr       (addr),
    .size       (size),
    .we         (we),
    .wdata      (wdata),
    .hit        (acc_hit),
    .nbytes     (acc_nbytes),
    .low        (acc_low),
    .lane_we    (lane_we),
    .lane_row   (lane_row),
    .lane_wbyte (lane_wbyte)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    lanemem_bank #(
      .ROWS  (DEPTH_WORDS),
      .IDX_W (ROW_W)
    ) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lane_we[k]),
      .row   (lane_row[k]),
      .wbyte (lane_wbyte[k]),
      .rbyte (lane_rbyte[k])
    );
  end

  lanemem_align i_align (
    .hit        (acc_hit),
    .nbytes     (acc_nbytes),
    .low        (acc_low),
    .sext       (sext),
    .lane_rbyte (lane_rbyte),
    .rdata      (rdata)
  );

endmodule

// File: rtl/lanemem_chk.sv
module lanemem_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic              we,
  input logic [31:0]       wdata,
  input logic              sext,
  input logic [31:0]       rdata,
  input logic              acc_hit,
  input logic [3:0]        lane_we
);

  logic [2:0] want_lanes;
  always_comb begin
    case (size)
      2'b00:   want_lanes = 3'd1;
      2'b01:   want_lanes = 3'd2;
      2'b10:   want_lanes = 3'd4;
      default: want_lanes = 3'd0;
    endcase
  end

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> rdata == 32'h0);                                             // R8
  AST_MISS_NO_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> lane_we == 4'h0);                                            // R8
  AST_RSVD_SIZE_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    size == 2'b11 |-> !acc_hit);                                              // R3
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && we) |-> $countones(lane_we) == 32'(want_lanes));              // R4
  AST_BYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && size == 2'b00 && sext) |-> rdata[31:8] == {24{rdata[7]}});    // R7
  AST_HALF_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && size == 2'b01 && !sext) |-> rdata[31:16] == 16'h0);           // R7
  AST_WORD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && we && size == 2'b10) |=>
      (!(size == 2'b10 && addr == $past(addr)) || rdata == $past(wdata)));    // R4

endmodule

bind lanemem_top lanemem_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .size    (size),
  .we      (we),
  .wdata   (wdata),
  .sext    (sext),
  .rdata   (rdata),
  .acc_hit (acc_hit),
  .lane_we (lane_we)
);

// File: tb/test_lanemem_top.sv
module test_lanemem_top;

  localparam int          PERIOD = 10;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned WIN    = DEPTH * 4;
  localparam logic [31:0] BASE   = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = BASE;
  logic [1:0]  size = 2'b10;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        sext = 1'b0;
  logic [31:0] rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] model_mem [WIN];

  always #(PERIOD/2) clk = ~clk;

  lanemem_top #(.ADDR_W(32), .BASE_ADDR(BASE), .DEPTH_WORDS(DEPTH)) i_lanemem_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .we(we),
    .wdata(wdata), .sext(sext), .rdata(rdata)
  );

  function automatic int count_of(input logic [1:0] s);
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 2;
    if (s == 2'b10) return 4;
    return 0;
  endfunction

  function automatic bit model_hit(input logic [31:0] a, input logic [1:0] s);
    longint off;
    int n = count_of(s);
    if (n == 0 || a < BASE) return 1'b0;
    off = longint'(a) - longint'(BASE);
    return (off + n) <= WIN;
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a, input logic [1:0] s, input logic x);
    logic [31:0] v = '0;
    int n = count_of(s);
    int off;
    if (!model_hit(a, s)) return '0;
    off = int'(a - BASE);
    for (int i = 0; i < n; i++) v[8*i +: 8] = model_mem[off + i];
    if (x && n < 4 && v[8*n-1]) for (int b = 8*n; b < 32; b++) v[b] = 1'b1;
    return v;
  endfunction

  task automatic model_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
    int off;
    if (!model_hit(a, s)) return;
    off = int'(a - BASE);
    for (int i = 0; i < count_of(s); i++) model_mem[off + i] = d[8*i +: 8];
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: addr=%h size=%0d got %h expected %h", req, addr, size, act, exp);
    end
  endtask

  // Inputs change at the falling edge; rdata is compared 1 time unit later.
  task automatic step(input string req, input logic [31:0] a, input logic [1:0] s,
                      input logic w, input logic [31:0] d, input logic x);
    addr = a; size = s; we = w; wdata = d; sext = x;
    #1;
    check(req, rdata, model_read(a, s, x));
    @(posedge clk);
    if (w) model_write(a, s, d);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < WIN; i++) model_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    step("R1", BASE, 2'b10, 1'b0, '0, 1'b0);
    step("R1", BASE + 60, 2'b10, 1'b0, '0, 1'b0);
    check("R1 literal", rdata, 32'h0);

    // R4 / R9: aligned word store, old contents visible during the store
    step("R9", BASE + 4, 2'b10, 1'b1, 32'h8899_AABB, 1'b0);
    step("R4", BASE + 4, 2'b10, 1'b0, '0, 1'b0);
    check("R4 literal", rdata, 32'h8899_AABB);

    // R7: byte and halfword extension
    step("R7", BASE + 4, 2'b00, 1'b0, '0, 1'b1);
    step("R7", BASE + 4, 2'b00, 1'b0, '0, 1'b0);
    step("R7", BASE + 6, 2'b01, 1'b0, '0, 1'b1);
    step("R7", BASE + 6, 2'b01, 1'b0, '0, 1'b0);

    // R6: halfword store across a word boundary, then crossing loads
    step("R6", BASE + 7, 2'b01, 1'b1, 32'h0000_1234, 1'b0);
    step("R6", BASE + 4, 2'b10, 1'b0, '0, 1'b0);
    check("R6 literal", rdata, 32'h3499_AABB);
    step("R6", BASE + 5, 2'b10, 1'b0, '0, 1'b0);
    check("R5 literal", rdata, 32'h1234_99AA);
    step("R6", BASE + 7, 2'b01, 1'b0, '0, 1'b1);

    // R2: window edges
    step("R2", BASE + 62, 2'b10, 1'b1, 32'hCAFE_F00D, 1'b0);
    step("R2", BASE + 62, 2'b00, 1'b0, '0, 1'b0);
    step("R2", BASE + 63, 2'b00, 1'b1, 32'h0000_007F, 1'b0);
    step("R2", BASE + 63, 2'b00, 1'b0, '0, 1'b1);
    step("R2", BASE + 60, 2'b10, 1'b1, 32'h0102_0304, 1'b0);
    step("R2", BASE + 60, 2'b10, 1'b0, '0, 1'b0);

    // R8: stores past the window end or below the base touch nothing
    step("R8", BASE + WIN, 2'b10, 1'b1, 32'hDEAD_BEEF, 1'b0);
    step("R8", BASE, 2'b10, 1'b0, '0, 1'b0);
    check("R8 literal", rdata, 32'h0);
    step("R8", BASE - 1, 2'b01, 1'b1, 32'h0000_5555, 1'b0);
    step("R8", BASE, 2'b00, 1'b0, '0, 1'b0);
    step("R8", BASE - 4, 2'b10, 1'b0, '0, 1'b0);

    // R3: reserved size neither writes nor reads
    step("R3", BASE + 4, 2'b11, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step("R3", BASE + 4, 2'b10, 1'b0, '0, 1'b0);
    step("R3", BASE + 4, 2'b11, 1'b0, '0, 1'b1);
    check("R3 literal", rdata, 32'h0);

    // R5: random traffic around and inside the window, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra = BASE - 4 + 32'($urandom_range(0, WIN + 7));
      logic [1:0]  rs = 2'($urandom_range(0, 3));
      step("R5", ra, rs, 1'($urandom_range(0, 1)), $urandom(), 1'($urandom_range(0, 1)));
    end

    // R1: reset mid-run clears everything again
    rst_n = 1'b0;
    for (int i = 0; i < WIN; i++) model_mem[i] = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < int'(DEPTH); w++) step("R1", BASE + 32'(4 * w), 2'b10, 1'b0, '0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule